// File: doc/BRIEF.md
# Fixed-Priority Lockable Bus Arbiter

This block decides which of four bus masters owns a shared bus. Each master raises an active-low request; the arbiter answers with one active-low grant, taken from clock flops, so grants change only on clock edges. Master 0 always wins over master 1, master 1 over master 2, and so on down to master 3.

The current owner can pull an active-low lock line to keep the bus through a multi-cycle transfer. While the lock is held, no other master is granted. If a master with higher priority than the owner asks for the bus during a lock, the owner's grant is taken away at once as a warning, but the bus itself stays with the owner. The waiting master gets its grant only once the lock is let go. Every change of owner passes through one clock in which no grant is active, so two masters never drive the bus in adjacent cycles.

Top module: `lock_arbiter`

## Requirements
- R1: A synchronous active-high reset sets all four grant outputs high (inactive) after the edge on which it is sampled.
- R2: At most one bit of the grant output is low in any cycle.
- R3: Bit i of the request input and bit i of the grant output belong to master i, and a lower index means higher priority; with no owner and the lock high, the lowest-indexed requester is granted on the next clock edge.
- R4: With the lock high, an owner that keeps requesting and sees no request from a lower-indexed master keeps its grant.
- R5: With the lock high, a request from a lower-indexed master removes the owner's grant on the next edge, and the new master is granted one edge later, leaving exactly one cycle with no grant.
- R6: With the lock high, an owner that stops requesting loses its grant on the next edge; with no requests pending all grants stay high.
- R7: While the lock is low and no grant is active, no grant is issued, whatever requests are pending.
- R8: While the lock is low, a request from a master with a lower index than the owner removes the owner's grant on the next edge.
- R9: After a grant was removed under lock, the edge that first samples the lock high gives no grant, and the next edge grants the lowest-indexed requester.
- R10: While the lock is low and no lower-indexed master requests, the owner keeps its grant, even if it stops requesting or higher-indexed masters request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all grant changes occur on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 4 | Bus requests, active low, bit i for master i |
| lock_n | input | 1 | Bus lock from the current owner, active low |
| gnt_n | output | 4 | Bus grants, active low, at most one low |

## Verification
From an idle bus every one of the fifteen non-empty request patterns is applied, which separates a correct lowest-index pick from any other bit ordering. Each pair of owner and higher-priority challenger is then run unlocked, telling a direct hand-over apart from the required empty cycle, and locked, telling a withdrawn grant from both a kept grant and an early hand-over. Lower-priority requests under lock, an owner dropping its request under lock, and a lock raised on an idle bus check that the lock neither leaks a grant nor steals one.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Ownership state of the shared bus
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,   // nobody owns the bus
        ARB_OWN  = 2'd1,   // owner holds bus and its grant
        ARB_HELD = 2'd2    // owner holds bus under lock, grant withdrawn
    } arb_state_e;

    // Only a fully owned bus drives a grant
    function automatic logic arb_drives_grant(arb_state_e st);
        return st == ARB_OWN;
    endfunction

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N_MASTERS = 4,
    localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    output logic                 found,
    output logic [IW-1:0]        idx
);

    // Lowest index wins: scan from the top so lower indices overwrite
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 locked,
    output arb_state_e           state,
    output logic [IW-1:0]        owner
);

    logic                 pick_found;
    logic [IW-1:0]        pick_idx;
    logic [N_MASTERS-1:0] above_owner;
    logic                 higher_pend;
    logic                 owner_req;
    arb_state_e           state_d;
    logic [IW-1:0]        owner_d;

    arb_prio_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .req   (req),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Requests from masters that outrank the owner
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_above
        assign above_owner[g] = req[g] && (IW'(g) < owner);
    end

    assign higher_pend = |above_owner;
    assign owner_req   = req[owner];

    always_comb begin
        state_d = state;
        owner_d = owner;
        unique case (state)
            ARB_IDLE: begin
                if (!locked && pick_found) begin
                    state_d = ARB_OWN;
                    owner_d = pick_idx;
                end
            end
            ARB_OWN: begin
                if (locked) begin
                    if (higher_pend) state_d = ARB_HELD;
                end else if (!owner_req || higher_pend) begin
                    state_d = ARB_IDLE;
                end
            end
            ARB_HELD: begin
                if (!locked) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
            owner <= '0;
        end else begin
            state <= state_d;
            owner <= owner_d;
        end
    end

    // A withdrawn grant only ever returns through an idle cycle
    assert_held_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ARB_HELD) |=> (state != ARB_OWN));

endmodule

// File: rtl/arb_grant_drv.sv
module arb_grant_drv
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 locked,
    input  arb_state_e           state,
    input  logic [IW-1:0]        owner,
    output logic [N_MASTERS-1:0] gnt_n
);

    logic drive;
    assign drive = arb_drives_grant(state);

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
        assign gnt_n[g] = !(drive && (owner == IW'(g)));
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(~gnt_n) <= 1);

    assert_idle_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt_n != '1) |=> ((gnt_n == $past(gnt_n)) || (gnt_n == '1)));

    assert_lock_nogrant_R7: assert property (@(posedge clk) disable iff (rst)
        (locked && (gnt_n == '1)) |=> (gnt_n == '1));

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_n,
    input  logic                 lock_n,
    output logic [N_MASTERS-1:0] gnt_n
);

    logic [N_MASTERS-1:0] req;
    logic                 locked;
    arb_state_e           state;
    logic [IW-1:0]        owner;

    assign req    = ~req_n;
    assign locked = ~lock_n;

    arb_ctrl #(.N_MASTERS(N_MASTERS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .locked (locked),
        .state  (state),
        .owner  (owner)
    );

    arb_grant_drv #(.N_MASTERS(N_MASTERS)) u_gnt (
        .clk    (clk),
        .rst    (rst),
        .locked (locked),
        .state  (state),
        .owner  (owner),
        .gnt_n  (gnt_n)
    );

    // Port-level view: grant one-hot and requests that outrank it
    logic [N_MASTERS-1:0] gnt_oh;
    logic [N_MASTERS-1:0] outrank;
    assign gnt_oh  = ~gnt_n;
    assign outrank = req & (gnt_oh - N_MASTERS'(1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_n && (gnt_oh != '0) && ((req & gnt_oh) != '0) && (outrank == '0))
        |=> $stable(gnt_n));

    assert_withdraw_R8: assert property (@(posedge clk) disable iff (rst)
        (!lock_n && (gnt_oh != '0) && (outrank != '0)) |=> (gnt_n == '1));

    assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (!lock_n && (gnt_oh != '0) && (outrank == '0)) |=> $stable(gnt_n));

endmodule

// File: tb/sim_lock_arbiter.sv
`timescale 1ns/1ps
module sim_lock_arbiter;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] req_n;
    logic       lock_n;
    logic [3:0] gnt_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    lock_arbiter #(.N_MASTERS(4)) u0 (
        .clk    (clk),
        .rst    (rst),
        .req_n  (req_n),
        .lock_n (lock_n),
        .gnt_n  (gnt_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [3:0] exp);
        n_checks++;
        if (gnt_n !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt_n actual %b expected %b", tag, gnt_n, exp);
        end
    endtask

    // Advance one edge, sample 1 ns later, check one-hot (R2)
    task automatic step();
        @(posedge clk);
        #1;
        n_checks++;
        if ($countones(~gnt_n) > 1) begin
            n_fail++;
            $display("FAIL R2: gnt_n actual %b expected at most one low", gnt_n);
        end
    endtask

    // Active-high mask to active-low pins
    function automatic logic [3:0] lo(input logic [3:0] m);
        return ~m;
    endfunction

    task automatic go_idle();
        req_n  = 4'hF;
        lock_n = 1'b1;
        step();
        step();
        chk("R6 idle", 4'hF);
    endtask

    initial begin
        rst    = 1'b1;
        req_n  = 4'hF;
        lock_n = 1'b1;
        step();
        chk("R1 reset", 4'hF);
        rst = 1'b0;

        // R3: every request pattern from idle, lowest set bit wins
        for (int p = 1; p < 16; p++) begin
            logic [3:0] pat;
            pat   = 4'(p);
            req_n = lo(pat);
            step();
            chk("R3 pick", lo(pat & (~pat + 4'd1)));
            step();
            chk("R4 hold", lo(pat & (~pat + 4'd1)));
            go_idle();
        end

        // R5: unlocked preemption leaves one empty cycle
        for (int o = 1; o < 4; o++) begin
            for (int h = 0; h < o; h++) begin
                req_n = lo(4'(1 << o));
                step();
                chk("R3 owner", lo(4'(1 << o)));
                req_n = lo(4'((1 << o) | (1 << h)));
                step();
                chk("R5 gap", 4'hF);
                step();
                chk("R5 new", lo(4'(1 << h)));
                go_idle();
            end
        end

        // R8/R9: locked preemption withdraws, hands over after release
        for (int o = 1; o < 4; o++) begin
            for (int h = 0; h < o; h++) begin
                req_n = lo(4'(1 << o));
                step();
                chk("R3 owner", lo(4'(1 << o)));
                lock_n = 1'b0;
                req_n  = lo(4'((1 << o) | (1 << h)));
                step();
                chk("R8 withdraw", 4'hF);
                for (int k = 0; k < 3; k++) begin
                    step();
                    chk("R8 held", 4'hF);
                end
                lock_n = 1'b1;
                step();
                chk("R9 release gap", 4'hF);
                step();
                chk("R9 handover", lo(4'(1 << h)));
                go_idle();
            end
        end

        // R10: lower-priority requests and owner drop under lock
        for (int o = 0; o < 3; o++) begin
            req_n = lo(4'(1 << o));
            step();
            chk("R3 owner", lo(4'(1 << o)));
            lock_n = 1'b0;
            req_n  = lo(4'(4'hF << o));
            step();
            chk("R10 lower req", lo(4'(1 << o)));
            req_n = lo(4'(4'hE << o));
            step();
            chk("R10 owner drop", lo(4'(1 << o)));
            lock_n = 1'b1;
            step();
            chk("R6 release", 4'hF);
            go_idle();
        end

        // R7: lock on an idle bus blocks all grants
        lock_n = 1'b0;
        req_n  = 4'h0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R7 locked idle", 4'hF);
        end
        lock_n = 1'b1;
        step();
        chk("R3 after lock", lo(4'b0001));

        // R1: reset during ownership
        rst = 1'b1;
        step();
        chk("R1 mid reset", 4'hF);
        rst = 1'b0;
        go_idle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule